// File: doc/BRIEF.md
# Banked Access-Violation Status Register

This block watches every access on a small register bus and records illegal ones in a 32-bit status word. Each access carries a valid, write, address, data and secure attribute. A class table, loaded through its own write port, gives each register word one access class: reserved, read-only, write-only or read-write. Words beyond the table count as reserved. Four kinds of illegal access each set one sticky flag. Software clears a flag by writing 1 to its bit. Two copies of the flags exist, one for secure accesses and one for non-secure accesses. The secure attribute of an access picks the copy that the access reads, clears and logs into.

The status word sits at byte offset 0x10 (word 4). An access to that word is always legal and is never classified. When `cfg_single` is 1 there is a single security state, and every access uses the non-secure copy. When `cfg_impl` is 0 the status word reads as zero, writes to it have no effect, and no violations are logged.

Reads return data through a small response state machine with two states. RSP_IDLE moves to RSP_DATA when a read is accepted. RSP_DATA stays in RSP_DATA on a further read and returns to RSP_IDLE otherwise. A violation passes through one event register before it reaches the flags.

Top module: `avsr_status_reg`

## Requirements
- R1: After reset, all flags in both copies are 0 and `rd_valid` is 0.
- R2: Bits 31:4 of the status word always read as 0, even when writes to the status word set bits 31:4 in `bus_wdata`.
- R3: A write to a read-only word (class code 2'b01) sets bit 3. A read of that word sets nothing.
- R4: A read of a write-only word (class code 2'b10) sets bit 2. A write to that word sets nothing.
- R5: A write to a reserved word (class code 2'b00, or any word at or beyond the table depth) sets bit 1.
- R6: A read of a reserved word sets bit 0.
- R7: Accesses to read-write words (class code 2'b11) set no flag. Accesses to the status word set no flag, whatever the table holds for word 4.
- R8: Writing 1 to a flag bit of the status word clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R9: With `cfg_single`=0, the secure attribute of an access selects the copy it reads and clears. A violation is logged only into the copy that matches the attribute of the offending access.
- R10: With `cfg_single`=1, every access reads, clears and logs into one shared copy, whatever its secure attribute.
- R11: With `cfg_impl`=0, a status read returns 0, a status write clears nothing, and violations are not logged.
- R12: When a violation's set and a software clear of the same bit land on the same edge, the bit stays set.
- R13: A read is answered with `rd_valid`=1 and its data exactly one cycle after it is accepted. A violation becomes visible to a status read issued two or more cycles after the offending access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_impl | input | 1 | 1 = status word implemented |
| cfg_single | input | 1 | 1 = single security state, one shared copy |
| tbl_we | input | 1 | Class table write strobe |
| tbl_idx | input | 4 | Class table word index |
| tbl_cls | input | 2 | Class code: 00 reserved, 01 read-only, 10 write-only, 11 read-write |
| bus_valid | input | 1 | Access valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_secure | input | 1 | Secure attribute of the access |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data (zero for words other than the status word) |

## Verification
Read data is due on the first clock edge after the edge that accepts the read. The bench drives every access at a falling edge and captures `rd_valid` and `rd_data` at the next falling edge, just after that response edge. A violation needs two edges to reach the flags: one into the event register and one into the copy. So the bench always leaves at least one idle cycle between a violating access and the status read that checks it. The only exception is the R12 case, where it deliberately issues the clear on the very next cycle so that set and clear meet on the same edge.

// File: rtl/avsr_pkg.sv
package avsr_pkg;

    typedef enum logic [1:0] {
        CLS_RSV = 2'b00,
        CLS_RO  = 2'b01,
        CLS_WO  = 2'b10,
        CLS_RW  = 2'b11
    } acc_class_e;

    localparam int NUM_FLAGS  = 4;
    localparam int FLG_RD_RSV = 0;
    localparam int FLG_WR_RSV = 1;
    localparam int FLG_RD_WO  = 2;
    localparam int FLG_WR_RO  = 3;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef enum logic {
        RSP_IDLE,
        RSP_DATA
    } rsp_state_e;

endpackage

// File: rtl/avsr_class_table.sv
module avsr_class_table
    import avsr_pkg::*;
#(
    parameter int TBL_WORDS = 16,
    parameter int WORD_W    = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(TBL_WORDS)-1:0] wr_idx,
    input  acc_class_e                   wr_cls,
    input  logic [WORD_W-1:0]            lk_word,
    output acc_class_e                   lk_cls
);
    localparam int IDX_W = $clog2(TBL_WORDS);

    acc_class_e tbl_q [TBL_WORDS];

    for (genvar e = 0; e < TBL_WORDS; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_q[e] <= CLS_RSV;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                tbl_q[e] <= wr_cls;
            end
        end
    end

    logic in_range;
    assign in_range = (32'(lk_word) < 32'(TBL_WORDS));

    always_comb begin
        if (in_range) begin
            lk_cls = tbl_q[lk_word[IDX_W-1:0]];
        end else begin
            lk_cls = CLS_RSV;
        end
    end

endmodule

// File: rtl/avsr_violation_det.sv
module avsr_violation_det
    import avsr_pkg::*;
#(
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_is_status,
    input  acc_class_e        acc_cls,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic              log_en,
    output flag_vec_t         ev_q,
    output logic [BANK_W-1:0] ev_bank_q
);
    flag_vec_t ev_d;

    always_comb begin
        ev_d = '0;
        if (acc_valid && log_en && !acc_is_status) begin
            unique case (acc_cls)
                CLS_RSV: begin
                    if (acc_write) ev_d[FLG_WR_RSV] = 1'b1;
                    else           ev_d[FLG_RD_RSV] = 1'b1;
                end
                CLS_RO: begin
                    if (acc_write) ev_d[FLG_WR_RO] = 1'b1;
                end
                CLS_WO: begin
                    if (!acc_write) ev_d[FLG_RD_WO] = 1'b1;
                end
                CLS_RW: begin
                    ev_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q      <= '0;
            ev_bank_q <= '0;
        end else begin
            ev_q      <= ev_d;
            ev_bank_q <= acc_bank;
        end
    end

endmodule

// File: rtl/avsr_flag_bank.sv
module avsr_flag_bank
    import avsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_vec,
    output flag_vec_t flags_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/avsr_status_reg.sv
module avsr_status_reg
    import avsr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int TBL_WORDS  = 16,
    parameter int STATUS_OFS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_impl,
    input  logic                         cfg_single,
    input  logic                         tbl_we,
    input  logic [$clog2(TBL_WORDS)-1:0] tbl_idx,
    input  logic [1:0]                   tbl_cls,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic                         bus_secure,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int WORD_W    = ADDR_W - 2;
    localparam int NUM_BANKS = 2;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam logic [WORD_W-1:0] STATUS_WORD = WORD_W'(STATUS_OFS / 4);

    logic [WORD_W-1:0] acc_word;
    logic              is_status;
    logic [BANK_W-1:0] acc_bank;
    logic              wr_status;
    acc_class_e        lk_cls;
    flag_vec_t         ev_q;
    logic [BANK_W-1:0] ev_bank_q;
    flag_vec_t         bank_flags [NUM_BANKS];
    logic [NUM_BANKS*NUM_FLAGS-1:0] flags_all;

    assign acc_word  = bus_addr[ADDR_W-1:2];
    assign is_status = (acc_word == STATUS_WORD);
    assign acc_bank  = cfg_single ? '0 : BANK_W'(bus_secure);
    assign wr_status = bus_valid && bus_write && is_status && cfg_impl;

    avsr_class_table #(
        .TBL_WORDS (TBL_WORDS),
        .WORD_W    (WORD_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_cls  (acc_class_e'(tbl_cls)),
        .lk_word (acc_word),
        .lk_cls  (lk_cls)
    );

    avsr_violation_det #(
        .BANK_W (BANK_W)
    ) u_det (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (bus_valid),
        .acc_write     (bus_write),
        .acc_is_status (is_status),
        .acc_cls       (lk_cls),
        .acc_bank      (acc_bank),
        .log_en        (cfg_impl),
        .ev_q          (ev_q),
        .ev_bank_q     (ev_bank_q)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        flag_vec_t set_b;
        flag_vec_t clr_b;

        assign set_b = (ev_bank_q == BANK_W'(b)) ? ev_q : '0;
        assign clr_b = (wr_status && (acc_bank == BANK_W'(b)))
                       ? bus_wdata[NUM_FLAGS-1:0] : '0;

        avsr_flag_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_b),
            .clr_vec (clr_b),
            .flags_q (bank_flags[b])
        );

        assign flags_all[b*NUM_FLAGS +: NUM_FLAGS] = bank_flags[b];
    end

    // read response state machine
    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic              rd_accept;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;

    assign rd_accept = bus_valid && !bus_write;

    always_comb begin
        rd_word = '0;
        if (cfg_impl && is_status) begin
            rd_word[NUM_FLAGS-1:0] = bank_flags[acc_bank];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: if (rd_accept)  state_d = RSP_DATA;
            RSP_DATA: if (!rd_accept) state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_accept) rdata_q <= rd_word;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            RSP_IDLE: rd_valid = 1'b0;
            RSP_DATA: begin
                rd_valid = 1'b1;
                rd_data  = rdata_q;
            end
        endcase
    end

endmodule

// File: rtl/avsr_status_reg_chk.sv
module avsr_status_reg_chk #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int STATUS_OFS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_impl,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [7:0]        flags_all,
    input logic [3:0]        ev_q
);
    logic at_status;
    assign at_status = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(STATUS_OFS / 4));

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid); // R13

    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rd_valid); // R13

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[DATA_W-1:4] == '0)); // R2

    AST_NOIMPL_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !cfg_impl) |=> (rd_data == '0)); // R11

    AST_STATUS_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && at_status) |=> (ev_q == '0)); // R7

    AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags_all) & ~flags_all)) |->
            $past(bus_valid && bus_write && at_status && cfg_impl)); // R8

endmodule

bind avsr_status_reg avsr_status_reg_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STATUS_OFS (STATUS_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_impl  (cfg_impl),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .flags_all (flags_all),
    .ev_q      (ev_q)
);

// File: tb/avsr_status_reg_bench.sv
`timescale 1ns/1ps
module avsr_status_reg_bench;
    localparam logic [7:0] ST = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_impl = 1'b1;
    logic        cfg_single = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [1:0]  tbl_cls = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_secure = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    logic        got_v;
    logic [31:0] got_d;

    always #2.5 clk = ~clk;

    avsr_status_reg u_avsr_status_reg (
        .clk(clk), .rst_n(rst_n), .cfg_impl(cfg_impl), .cfg_single(cfg_single),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_cls(tbl_cls),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_secure(bus_secure),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d; bus_secure = s;
        @(negedge clk);
        got_v = rd_valid; got_d = rd_data;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_chk(input logic s, input logic [31:0] exp, input string tag);
        acc(1'b0, ST, 32'h0, s);
        chk({tag, " rd_valid"}, {31'h0, got_v}, 32'h1);
        chk(tag, got_d, exp);
    endtask

    task automatic clr_all();
        acc(1'b1, ST, 32'hF, 1'b0);
        acc(1'b1, ST, 32'hF, 1'b1);
    endtask

    function automatic logic [3:0] ev_of(int c, logic w);
        case (c)
            0: return w ? 4'h2 : 4'h1;
            1: return w ? 4'h8 : 4'h0;
            2: return w ? 4'h0 : 4'h4;
            default: return 4'h0;
        endcase
    endfunction

    function automatic string tag_of(int c, logic w);
        case (c)
            0: return w ? "R5/R9" : "R6/R9";
            1: return "R3/R9";
            2: return "R4/R9";
            default: return "R7/R9";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_valid idle", {31'h0, rd_valid}, 32'h0);
        rd_chk(1'b0, 32'h0, "R1 ns copy");
        rd_chk(1'b1, 32'h0, "R1 s copy");

        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_idx = 4'(c); tbl_cls = 2'(c);
        end
        @(negedge clk);
        tbl_we = 1'b0;

        // sweep: single mode x class x direction x attribute
        for (int sg = 0; sg < 2; sg++) begin
            cfg_single = 1'(sg);
            for (int c = 0; c < 4; c++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [3:0] e;
                        clr_all();
                        acc(1'(w), 8'(c * 4), 32'h0, 1'(s));
                        e = ev_of(c, 1'(w));
                        for (int rs = 0; rs < 2; rs++) begin
                            logic [31:0] exp;
                            exp = (sg == 1 || rs == s) ? {28'h0, e} : 32'h0;
                            rd_chk(1'(rs), exp, sg == 1 ? "R10" : tag_of(c, 1'(w)));
                        end
                    end
                end
            end
        end
        cfg_single = 1'b0;
        clr_all();

        // write does not produce a response
        acc(1'b1, 8'h0C, 32'h0, 1'b0);
        chk("R13 no resp on write", {31'h0, got_v}, 32'h0);

        // words beyond the table are reserved
        acc(1'b1, 8'h80, 32'h0, 1'b0);
        acc(1'b0, 8'hFC, 32'h0, 1'b0);
        rd_chk(1'b0, 32'h3, "R5 R6 beyond table");
        clr_all();

        // status word itself never flags (table word 4 is reserved)
        acc(1'b0, ST, 32'h0, 1'b1);
        acc(1'b1, ST, 32'h0, 1'b1);
        acc(1'b0, 8'h12, 32'h0, 1'b1);
        rd_chk(1'b1, 32'h0, "R7 status access");

        // all four flags, upper bits stay zero
        acc(1'b1, 8'h04, 32'h0, 1'b0);
        acc(1'b0, 8'h08, 32'h0, 1'b0);
        acc(1'b1, 8'h00, 32'h0, 1'b0);
        acc(1'b0, 8'h00, 32'h0, 1'b0);
        acc(1'b1, ST, 32'hFFFF_FFF0, 1'b0);
        rd_chk(1'b0, 32'hF, "R2 upper zero");

        // partial W1C and write of zero
        acc(1'b1, ST, 32'h5, 1'b0);
        rd_chk(1'b0, 32'hA, "R8 partial clear");
        acc(1'b1, ST, 32'h0, 1'b0);
        rd_chk(1'b0, 32'hA, "R8 zero write");
        acc(1'b1, ST, 32'hA, 1'b1);
        rd_chk(1'b0, 32'hA, "R9 other copy clear");
        acc(1'b1, ST, 32'hA, 1'b0);
        rd_chk(1'b0, 32'h0, "R8 full clear");

        // set and clear meeting on one edge
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h04; bus_secure = 1'b0;
        @(negedge clk);
        bus_addr = ST; bus_wdata = 32'h8;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rd_chk(1'b0, 32'h8, "R12 set wins");

        // not implemented: RAZ/WI and no logging
        cfg_impl = 1'b0;
        rd_chk(1'b0, 32'h0, "R11 raz");
        acc(1'b1, ST, 32'hF, 1'b0);
        acc(1'b1, 8'h00, 32'h0, 1'b0);
        cfg_impl = 1'b1;
        rd_chk(1'b0, 32'h8, "R11 wi and no log");

        // response back to back reads
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ST; bus_secure = 1'b0;
        @(negedge clk);
        chk("R13 first resp", {31'h0, rd_valid}, 32'h1);
        bus_secure = 1'b1;
        @(negedge clk);
        chk("R13 second resp", {31'h0, rd_valid}, 32'h1);
        chk("R13 second data", rd_data, 32'h0);
        bus_valid = 1'b0;
        @(negedge clk);
        chk("R13 idle after", {31'h0, rd_valid}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule